// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Service Tracker

This block keeps the interrupt state for a two-channel serial controller. Each channel reports three kinds of event as single-cycle pulses: a received character became available, the transmit buffer went empty, and the transmit buffer was written. From these pulses the block keeps per-channel pending and in-service flags. It also keeps two shared registers: an 8-bit pending summary and an 8-bit vector code. The vector code names the source that was serviced most recently. Software clears service through two command codes written to a channel's command register.

A single interrupt line is the OR of the enabled requests of both channels. The vector code comes in one of two encodings, chosen by a status-placement mode bit. A receive interrupt that is in service blocks a transmit interrupt from taking service. Index 0 of every two-bit channel port is channel B, and index 1 is channel A.

Top module: `sio_irq_track`

## Requirements
- R1: After reset, `rr3_o` is 0x00, `vec_o` is 0x06 and `irq_o` is 0 while no request input is active.
- R2: A receive pulse on a channel sets that channel's receive pending and in-service flags and its `rr3_o` bit (bit 5 for A, bit 2 for B). On the next clock edge it loads `vec_o` with 0x0C for A or 0x04 for B when `stat_hi_i` is 0.
- R3: With `stat_hi_i` set, the loaded codes are 0x30 for receive A, 0x20 for receive B, 0x10 for transmit A and 0x60 for no interrupt. Transmit B loads 0x00 in both modes. With `stat_hi_i` clear, transmit A is 0x08 and no interrupt is 0x06.
- R4: A transmit-empty pulse always sets the channel's transmit pending flag. The transmit in-service flag and the vector are taken only when the channel has no receive interrupt in service. The `rr3_o` bit (bit 4 for A, bit 1 for B) is set only in that case and only when the channel's `tx_ie_i` is 1.
- R5: A command with bits 5:3 = 111 (0x38) resets the highest in-service source of the channel. If a receive is in service, it clears the receive in-service and pending flags and the receive `rr3_o` bit. Otherwise, if a transmit is in service, it clears the transmit ones. The vector returns to the no-interrupt code. If nothing is in service, the command changes nothing.
- R6: A command with bits 5:3 = 101 (0x28) clears the channel's transmit pending and in-service flags and its transmit `rr3_o` bit, and loads the no-interrupt code.
- R7: A transmit-write pulse clears the transmit interrupt like R6. A later transmit-empty pulse raises it again.
- R8: `irq_o` is combinational. It is 1 when, in either channel, any of these holds: `tx_ie_i` is set with transmit pending; the receive mode field is 01 or 10 with receive pending; or `brk_ie_i` and `brk_i` are both 1. Receive modes 00 and 11 mask receive requests.
- R9: Events of one cycle apply within a channel in this order: command, transmit write, receive pulse, transmit-empty pulse. When both channels update the vector in the same cycle, channel A's code wins.
- R10: `rr3_o` bits 7, 6, 3 and 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_avail_i | input | 2 | Receive character available pulse per channel |
| tx_empty_i | input | 2 | Transmit buffer empty pulse per channel |
| tx_write_i | input | 2 | Transmit buffer written pulse per channel |
| cmd_wr_i | input | 2 | Command register write strobe per channel |
| cmd_i | input | 8 | Command byte; bits 5:3 carry the code |
| tx_ie_i | input | 2 | Transmit interrupt enable per channel |
| rx_mode_i | input | 4 | Receive interrupt mode, [1:0] channel B, [3:2] channel A |
| brk_ie_i | input | 2 | Break interrupt enable per channel |
| brk_i | input | 2 | Break condition present per channel |
| stat_hi_i | input | 1 | Selects the high-position vector encoding |
| irq_o | output | 1 | Interrupt request line |
| rr3_o | output | 8 | Shared pending summary |
| vec_o | output | 8 | Shared vector code |

## Verification
Flags, `rr3_o` and `vec_o` change at the first clock edge after a pulse. The bench drives every input at the falling edge and reads these outputs at the next falling edge, after exactly one register stage. `irq_o` has no register, so it follows the current state and the enable and break inputs in the same cycle. The bench compares it one time step after new inputs are applied and before the edge. A behavioural model steps on each rising edge, and both kinds of result are compared against it every cycle.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

    localparam int unsigned NUM_CH = 2;
    localparam int unsigned VEC_W  = 8;

    // command field values (bits 5:3 of the command byte)
    localparam logic [2:0] CMD_RST_TX  = 3'b101;
    localparam logic [2:0] CMD_RST_IUS = 3'b111;

    typedef enum logic [1:0] {
        VACT_NONE = 2'd0,
        VACT_IDLE = 2'd1,
        VACT_RX   = 2'd2,
        VACT_TX   = 2'd3
    } vact_e;

    typedef struct packed {
        logic rx_pend;
        logic tx_pend;
        logic rx_ius;
        logic tx_ius;
        logic rr3_tx;
    } chan_state_t;

    function automatic logic [VEC_W-1:0] vec_code(vact_e act, logic is_a, logic hi);
        logic [VEC_W-1:0] c;
        case (act)
            VACT_RX: c = is_a ? (hi ? 8'h30 : 8'h0C) : (hi ? 8'h20 : 8'h04);
            VACT_TX: c = is_a ? (hi ? 8'h10 : 8'h08) : 8'h00;
            default: c = hi ? 8'h60 : 8'h06;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sio_irq_chan.sv
module sio_irq_chan
    import sio_irq_pkg::*;
#(
    parameter bit IS_A = 1'b0
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       rx_set_i,
    input  logic       tx_empty_i,
    input  logic       tx_write_i,
    input  logic       cmd_wr_i,
    input  logic [2:0] cmd_code_i,
    input  logic       tx_ie_i,
    input  logic [1:0] rx_mode_i,
    input  logic       brk_ie_i,
    input  logic       brk_i,
    output logic       rr3_rx_o,
    output logic       rr3_tx_o,
    output vact_e      vact_o,
    output logic       req_o
);

    chan_state_t st_d, st_q;
    vact_e       act_d;

    always_comb begin
        st_d  = st_q;
        act_d = VACT_NONE;
        if (cmd_wr_i) begin
            if (cmd_code_i == CMD_RST_IUS) begin
                if (st_q.rx_ius) begin
                    st_d.rx_ius  = 1'b0;
                    st_d.rx_pend = 1'b0;
                    act_d        = VACT_IDLE;
                end else if (st_q.tx_ius) begin
                    st_d.tx_ius  = 1'b0;
                    st_d.tx_pend = 1'b0;
                    st_d.rr3_tx  = 1'b0;
                    act_d        = VACT_IDLE;
                end
            end else if (cmd_code_i == CMD_RST_TX) begin
                st_d.tx_ius  = 1'b0;
                st_d.tx_pend = 1'b0;
                st_d.rr3_tx  = 1'b0;
                act_d        = VACT_IDLE;
            end
        end
        if (tx_write_i) begin
            st_d.tx_ius  = 1'b0;
            st_d.tx_pend = 1'b0;
            st_d.rr3_tx  = 1'b0;
            act_d        = VACT_IDLE;
        end
        if (rx_set_i) begin
            st_d.rx_pend = 1'b1;
            st_d.rx_ius  = 1'b1;
            act_d        = VACT_RX;
        end
        if (tx_empty_i) begin
            st_d.tx_pend = 1'b1;
            if (!st_d.rx_ius) begin
                st_d.tx_ius = 1'b1;
                if (tx_ie_i) st_d.rr3_tx = 1'b1;
                act_d = VACT_TX;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign vact_o   = act_d;
    assign rr3_rx_o = st_q.rx_pend;
    assign rr3_tx_o = st_q.rr3_tx;
    assign req_o    = (st_q.tx_pend & tx_ie_i)
                    | (((rx_mode_i == 2'b01) || (rx_mode_i == 2'b10)) & st_q.rx_pend)
                    | (brk_ie_i & brk_i);

    assert_rx_takes_ius_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_set_i |=> (st_q.rx_ius && st_q.rx_pend));

    assert_tx_blocked_by_rx_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_empty_i && st_q.rx_ius && !st_q.tx_ius && !cmd_wr_i && !tx_write_i)
        |=> (!st_q.tx_ius && st_q.tx_pend));

    assert_write_clears_tx_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_write_i && !tx_empty_i) |=> (!st_q.tx_pend && !st_q.rr3_tx));

    assert_rr3_tx_has_pend_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.rr3_tx |-> (st_q.tx_pend && st_q.tx_ius));

endmodule

// File: rtl/sio_irq_vec.sv
module sio_irq_vec
    import sio_irq_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  vact_e            vact_b_i,
    input  vact_e            vact_a_i,
    input  logic             stat_hi_i,
    output logic [VEC_W-1:0] vec_o
);

    logic [VEC_W-1:0] vec_d, vec_q;

    always_comb begin
        vec_d = vec_q;
        if (vact_a_i != VACT_NONE)      vec_d = vec_code(vact_a_i, 1'b1, stat_hi_i);
        else if (vact_b_i != VACT_NONE) vec_d = vec_code(vact_b_i, 1'b0, stat_hi_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) vec_q <= 8'h06;
        else         vec_q <= vec_d;
    end

    assign vec_o = vec_q;

    assert_vec_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_q inside {8'h00, 8'h04, 8'h06, 8'h08, 8'h0C, 8'h10, 8'h20, 8'h30, 8'h60});

    assert_a_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vact_a_i == VACT_RX) |=> (vec_q == 8'h0C || vec_q == 8'h30));

endmodule

// File: rtl/sio_irq_track.sv
module sio_irq_track
    import sio_irq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] rx_avail_i,
    input  logic [1:0] tx_empty_i,
    input  logic [1:0] tx_write_i,
    input  logic [1:0] cmd_wr_i,
    input  logic [7:0] cmd_i,
    input  logic [1:0] tx_ie_i,
    input  logic [3:0] rx_mode_i,
    input  logic [1:0] brk_ie_i,
    input  logic [1:0] brk_i,
    input  logic       stat_hi_i,
    output logic       irq_o,
    output logic [7:0] rr3_o,
    output logic [7:0] vec_o
);

    logic  [NUM_CH-1:0] rr3_rx, rr3_tx, req;
    vact_e              vact [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        sio_irq_chan #(.IS_A(g == 1)) u_chan (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .rx_set_i   (rx_avail_i[g]),
            .tx_empty_i (tx_empty_i[g]),
            .tx_write_i (tx_write_i[g]),
            .cmd_wr_i   (cmd_wr_i[g]),
            .cmd_code_i (cmd_i[5:3]),
            .tx_ie_i    (tx_ie_i[g]),
            .rx_mode_i  (rx_mode_i[2*g +: 2]),
            .brk_ie_i   (brk_ie_i[g]),
            .brk_i      (brk_i[g]),
            .rr3_rx_o   (rr3_rx[g]),
            .rr3_tx_o   (rr3_tx[g]),
            .vact_o     (vact[g]),
            .req_o      (req[g])
        );
    end

    sio_irq_vec u_vec (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .vact_b_i  (vact[0]),
        .vact_a_i  (vact[1]),
        .stat_hi_i (stat_hi_i),
        .vec_o     (vec_o)
    );

    assign rr3_o = {2'b00, rr3_rx[1], rr3_tx[1], 1'b0, rr3_rx[0], rr3_tx[0], 1'b0};
    assign irq_o = |req;

    assert_rx_mode_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((rx_mode_i[3:2] == 2'b01) && rr3_o[5]) |-> irq_o);

    assert_rr3_tx_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rr3_o[1] && tx_ie_i[0]) |-> irq_o);

endmodule

// File: tb/tb_sio_irq_track.sv
module tb_sio_irq_track;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rx_avail = '0, tx_empty = '0, tx_write = '0, cmd_wr = '0;
    logic [7:0] cmd = '0;
    logic [1:0] tx_ie = '0, brk_ie = '0, brk = '0;
    logic [3:0] rx_mode = '0;
    logic       stat_hi = 1'b0;
    logic       irq;
    logic [7:0] rr3, vec;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // model state, index 0 = B, 1 = A
    bit m_rxp [2], m_txp [2], m_rxs [2], m_txs [2], m_r3t [2];
    int m_vec = 'h06;

    always #5 clk = ~clk;

    sio_irq_track dut (
        .clk_i(clk), .rst_ni(rst_n), .rx_avail_i(rx_avail), .tx_empty_i(tx_empty),
        .tx_write_i(tx_write), .cmd_wr_i(cmd_wr), .cmd_i(cmd), .tx_ie_i(tx_ie),
        .rx_mode_i(rx_mode), .brk_ie_i(brk_ie), .brk_i(brk), .stat_hi_i(stat_hi),
        .irq_o(irq), .rr3_o(rr3), .vec_o(vec)
    );

    task automatic chk(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    function automatic int code_of(int kind, int ch, bit hi);
        // kind 0 none, 1 rx, 2 tx
        if (kind == 1) return ch == 1 ? (hi ? 'h30 : 'h0C) : (hi ? 'h20 : 'h04);
        if (kind == 2) return ch == 1 ? (hi ? 'h10 : 'h08) : 'h00;
        return hi ? 'h60 : 'h06;
    endfunction

    function automatic int m_rr3();
        return (m_rxp[1] << 5) | (m_r3t[1] << 4) | (m_rxp[0] << 2) | (m_r3t[0] << 1);
    endfunction

    function automatic int m_irq();
        int r = 0;
        for (int c = 0; c < 2; c++) begin
            int md = (rx_mode >> (2 * c)) & 3;
            if (tx_ie[c] && m_txp[c]) r = 1;
            if ((md == 1 || md == 2) && m_rxp[c]) r = 1;
            if (brk_ie[c] && brk[c]) r = 1;
        end
        return r;
    endfunction

    task automatic model_step();
        int newv = -1;
        for (int c = 0; c < 2; c++) begin
            int kind = -1;
            if (cmd_wr[c] && cmd[5:3] == 3'b111) begin
                if (m_rxs[c]) begin m_rxs[c] = 0; m_rxp[c] = 0; kind = 0; end
                else if (m_txs[c]) begin m_txs[c] = 0; m_txp[c] = 0; m_r3t[c] = 0; kind = 0; end
            end else if (cmd_wr[c] && cmd[5:3] == 3'b101) begin
                m_txs[c] = 0; m_txp[c] = 0; m_r3t[c] = 0; kind = 0;
            end
            if (tx_write[c]) begin m_txs[c] = 0; m_txp[c] = 0; m_r3t[c] = 0; kind = 0; end
            if (rx_avail[c]) begin m_rxp[c] = 1; m_rxs[c] = 1; kind = 1; end
            if (tx_empty[c]) begin
                m_txp[c] = 1;
                if (!m_rxs[c]) begin
                    m_txs[c] = 1;
                    if (tx_ie[c]) m_r3t[c] = 1;
                    kind = 2;
                end
            end
            if (kind >= 0) newv = code_of(kind, c, stat_hi);
        end
        if (newv >= 0) m_vec = newv;
    endtask

    // apply held inputs for one cycle, compare to model
    task automatic tick();
        #1 chk("R8 model irq", irq, m_irq());
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R9 model rr3", rr3, m_rr3());
        chk("R9 model vec", vec, m_vec);
        rx_avail = '0; tx_empty = '0; tx_write = '0; cmd_wr = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 chk("R1 irq", irq, 0);
        chk("R1 rr3", rr3, 'h00);
        chk("R1 vec", vec, 'h06);
        rst_n = 1'b1;
        @(negedge clk);
        tx_ie = 2'b11; rx_mode = 4'b0001;

        rx_avail[0] = 1; tick();
        chk("R2 rr3 rx B", rr3, 'h04); chk("R2 vec rx B", vec, 'h04);
        #1 chk("R8 irq rx B", irq, 1);

        tx_empty[0] = 1; tick();
        chk("R4 rr3 tx blocked", rr3, 'h04); chk("R4 vec kept", vec, 'h04);

        cmd_wr[0] = 1; cmd = 'h38; tick();
        chk("R5 rr3 rx cleared", rr3, 'h00); chk("R5 vec idle", vec, 'h06);
        #1 chk("R8 tx pend irq", irq, 1);

        stat_hi = 1; cmd_wr[0] = 1; cmd = 'h38; tick();
        chk("R5 nothing in service", vec, 'h06);

        cmd_wr[0] = 1; cmd = 'h28; tick();
        chk("R6 vec idle high", vec, 'h60);
        #1 chk("R6 irq low", irq, 0);

        rx_avail[1] = 1; tick();
        chk("R3 rr3 rx A", rr3, 'h20); chk("R3 vec rx A high", vec, 'h30);
        cmd_wr[1] = 1; cmd = 'h38; tick();
        tx_empty[1] = 1; tick();
        chk("R3 rr3 tx A", rr3, 'h10); chk("R3 vec tx A high", vec, 'h10);

        tx_write[1] = 1; tick();
        chk("R7 write clears rr3", rr3, 'h00); chk("R7 vec idle", vec, 'h60);
        tx_empty[1] = 1; tick();
        chk("R7 re-raise", rr3, 'h10);

        tx_empty[0] = 1; tick();
        chk("R3 vec tx B high", vec, 'h00);

        tx_ie[1] = 0; cmd_wr[1] = 1; cmd = 'h28; tick();
        tx_empty[1] = 1; tick();
        chk("R4 rr3 gated by enable", rr3 & 'h10, 'h00); chk("R4 vec tx A", vec, 'h10);

        stat_hi = 0; tx_ie[1] = 1;
        cmd_wr = 2'b11; cmd = 'h38; tick();
        rx_avail[0] = 1; tx_empty[1] = 1; tick();
        chk("R9 A wins vector", vec, 'h08);
        chk("R9 rr3 both", rr3 & 'h14, 'h14);
        chk("R10 unused rr3 bits", rr3 & 'hC9, 'h00);

        cmd_wr[1] = 1; cmd = 'h38; tick();
        rx_avail[1] = 1; tx_empty[1] = 1; tick();
        chk("R9 rx before tx", vec, 'h0C);

        tx_ie = 0; rx_mode = 4'b1100;
        #1 chk("R8 mode 11 masks", irq, 0);
        brk_ie[0] = 1; brk[0] = 1;
        #1 chk("R8 break", irq, 1);
        brk = 0; rx_mode = 4'b1000;
        #1 chk("R8 mode 10", irq, 1);

        for (int i = 0; i < 3000; i++) begin
            rx_avail = 2'($urandom_range(0, 3)) & 2'($urandom_range(0, 3));
            tx_empty = 2'($urandom_range(0, 3));
            tx_write = 2'($urandom_range(0, 3)) & 2'($urandom_range(0, 3));
            cmd_wr   = 2'($urandom_range(0, 3)) & 2'($urandom_range(0, 3));
            case ($urandom_range(0, 3))
                0: cmd = 'h28;
                1: cmd = 'h38;
                2: cmd = 'h10;
                default: cmd = 'h3B;
            endcase
            tx_ie   = 2'($urandom_range(0, 3));
            rx_mode = 4'($urandom_range(0, 15));
            brk_ie  = 2'($urandom_range(0, 3));
            brk     = 2'($urandom_range(0, 3)) & 2'($urandom_range(0, 3));
            stat_hi = 1'($urandom_range(0, 1));
            tick();
            chk("R10 unused bits", rr3 & 'hC9, 'h00);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule